// File: doc/BRIEF.md
# Serial-Loaded Quad DAC Register Controller

This block is the digital core of a four-channel digital-to-analog converter. A host shifts 16-bit command words in over a three-wire serial link (serial clock, serial data, and an active-low select that also acts as the load strobe). When the strobe returns high, the block acts on the word it holds. Each word carries a 4-bit address/control field, then a 10-bit code, then two padding bits, all most significant bit first. The field picks one channel, all channels, no channel, or a sleep command. The four held codes drive the converters. A sleep flag tells the analog side to power down. A serial output repeats the input stream 16 clocks late, so several devices can share one link in a chain.

All serial pins, including the clear input, are sampled by the block's own system clock through a synchronizer. Edges of the serial clock and of the strobe are found in that clock domain. The serial link must therefore run well below the system clock rate. The analog converters, buffers and reference are outside this block.

Top module: `quad_dac_ctrl`

## Requirements
- R1: After reset every channel code is zero, the sleep flag is clear and `dout` is low.
- R2: While `cs_ld` is low, each rising `sck` edge shifts `din` into the 16-bit word. While `cs_ld` is high, `sck` edges do not change the word.
- R3: A rising edge of `cs_ld` acts on the held word. The address is bits 15:12 and the code is bits 11:2. Address 1, 2, 3 or 4 writes the code into channel 0, 1, 2 or 3 respectively, and no other channel changes.
- R4: Address 15 (all ones) writes the same code into all four channels.
- R5: Address 0 changes no channel and clears the sleep flag.
- R6: Address 14 sets the sleep flag, ignores the code bits and changes no channel.
- R7: Any load with an address other than 14 or a reserved value clears the sleep flag. Channels that the load does not write keep the values they held before sleep.
- R8: Reserved addresses 5 through 13 change no channel and leave the sleep flag as it was.
- R9: `dout` changes only after a falling `sck` edge while `cs_ld` is low, and then shows bit 15 of the word. A bit that enters on rising edge k therefore appears after falling edge k+15 and is sampled downstream at rising edge k+16.
- R10: A low level on `clr_n` sets the shift word, `dout` and all channel codes to zero, and leaves the sleep flag unchanged.
- R11: No bit counter gates a load. A strobe after fewer or more than 16 clocks acts on the last 16 bits shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock |
| din | input | 1 | Serial data in, MSB first |
| cs_ld | input | 1 | Active-low select; its rising edge loads |
| clr_n | input | 1 | Active-low clear of the word and channel codes |
| dout | output | 1 | Serial data out for chaining |
| sleep | output | 1 | Power-down request to the analog side |
| code | output | 40 | Channel codes; channel n in bits 10n+9:10n |

## Verification
The bench builds the block with its defaults: four channels, 10-bit codes, a 4-bit address field, two padding bits and two synchronizer stages. With these values every address class is reachable: single-channel loads at 1 to 4, the reserved span 5 to 13, sleep at 14 and broadcast at 15. The 16-bit word makes the chaining delay and the word-length cases (20 and 8 clocked bits) directly observable. Sleep entry and exit are interleaved with loads so that codes held through sleep and the reserved codes' neutrality can both be seen at the ports.

// File: rtl/quad_dac_pkg.sv
// Shared types for the quad DAC register controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package quad_dac_pkg;

    // Class of action a captured address/control field asks for
    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_LOAD_ONE,
        CMD_LOAD_ALL,
        CMD_SLEEP,
        CMD_RESERVED
    } cmd_kind_e;

endpackage

// File: rtl/pin_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes each pin holds its level for longer than STAGES clk periods.
module pin_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);
    logic [W-1:0] stg [STAGES];

    // First stage captures the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= pin_i;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Further stages settle metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    endgenerate

    assign lvl_o = stg[STAGES-1];
endmodule

// File: rtl/word_shifter.sv
// Serial-in shift register with a chaining output taken from its last stage.
// Assumes the edge strobes are single-cycle pulses in the clk domain.
module word_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              sel_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              din_i,
    output logic [WORD_W-1:0] word_o,
    output logic              dout_o
);
    // Shift on a selected rising edge, clear on request
    always_ff @(posedge clk) begin
        if (!rst_n)              word_o <= '0;
        else if (clr_i)          word_o <= '0;
        else if (sel_i && rise_i) word_o <= {word_o[WORD_W-2:0], din_i};
    end

    // Present the last stage after a selected falling edge
    always_ff @(posedge clk) begin
        if (!rst_n)              dout_o <= 1'b0;
        else if (clr_i)          dout_o <= 1'b0;
        else if (sel_i && fall_i) dout_o <= word_o[WORD_W-1];
    end
endmodule

// File: rtl/cmd_decode.sv
// Decodes the address/control field into a channel write mask and a command class.
// Assumes NUM_CH+2 < 2**ADDR_W so the codes do not overlap.
module cmd_decode
    import quad_dac_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NUM_CH-1:0] mask_o,
    output cmd_kind_e         kind_o
);
    localparam logic [ADDR_W-1:0] ALL_CODE   = '1;
    localparam logic [ADDR_W-1:0] SLEEP_CODE = ALL_CODE - 1'b1;

    // Map the field to a class and the channels it writes
    always_comb begin
        mask_o = '0;
        kind_o = CMD_RESERVED;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr_i == ADDR_W'(i + 1)) begin
                mask_o[i] = 1'b1;
                kind_o    = CMD_LOAD_ONE;
            end
        end
        if (addr_i == '0) begin
            kind_o = CMD_NOP;
        end else if (addr_i == ALL_CODE) begin
            kind_o = CMD_LOAD_ALL;
            mask_o = '1;
        end else if (addr_i == SLEEP_CODE) begin
            kind_o = CMD_SLEEP;
        end
    end
endmodule

// File: rtl/channel_bank.sv
// Holds one code register per channel and writes the masked ones on a load.
// Assumes clear has priority over a load in the same cycle.
module channel_bank #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     load_i,
    input  logic [NUM_CH-1:0]        mask_i,
    input  logic [CODE_W-1:0]        data_i,
    output logic [NUM_CH*CODE_W-1:0] code_o
);
    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            // Per-channel code register
            always_ff @(posedge clk) begin
                if (!rst_n)                 code_o[g*CODE_W +: CODE_W] <= '0;
                else if (clr_i)             code_o[g*CODE_W +: CODE_W] <= '0;
                else if (load_i && mask_i[g]) code_o[g*CODE_W +: CODE_W] <= data_i;
            end
        end
    endgenerate
endmodule

// File: rtl/quad_dac_ctrl.sv
// Top of the quad DAC register controller: samples the serial pins, shifts
// command words, decodes them on the strobe's rising edge and keeps the
// channel codes and the sleep flag. Assumes sck phases and strobe gaps last
// several clk periods.
module quad_dac_ctrl
    import quad_dac_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int CODE_W      = 10,
    parameter int ADDR_W      = 4,
    parameter int PAD_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sck,
    input  logic                     din,
    input  logic                     cs_ld,
    input  logic                     clr_n,
    output logic                     dout,
    output logic                     sleep,
    output logic [NUM_CH*CODE_W-1:0] code
);
    localparam int WORD_W = ADDR_W + CODE_W + PAD_W;

    logic [3:0]        pins_s;
    logic              sck_s, din_s, cs_s, clr_act;
    logic              sck_prev, cs_prev;
    logic              sck_rise, sck_fall, load_stb, load_eff;
    logic [WORD_W-1:0] word_q;
    logic [ADDR_W-1:0] addr;
    logic [NUM_CH-1:0] wr_mask;
    cmd_kind_e         kind;

    pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({clr_n, cs_ld, din, sck}),
        .lvl_o (pins_s)
    );

    assign sck_s   = pins_s[0];
    assign din_s   = pins_s[1];
    assign cs_s    = pins_s[2];
    assign clr_act = ~pins_s[3];

    // Previous levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            sck_prev <= sck_s;
            cs_prev  <= cs_s;
        end
    end

    assign sck_rise = sck_s & ~sck_prev;
    assign sck_fall = ~sck_s & sck_prev;
    assign load_stb = cs_s & ~cs_prev;
    assign load_eff = load_stb & ~clr_act;

    word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_act),
        .sel_i  (~cs_s),
        .rise_i (sck_rise),
        .fall_i (sck_fall),
        .din_i  (din_s),
        .word_o (word_q),
        .dout_o (dout)
    );

    assign addr = word_q[WORD_W-1 -: ADDR_W];

    cmd_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr_i (addr),
        .mask_o (wr_mask),
        .kind_o (kind)
    );

    channel_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_act),
        .load_i (load_eff),
        .mask_i (wr_mask),
        .data_i (word_q[PAD_W +: CODE_W]),
        .code_o (code)
    );

    // Sleep flag: set by the sleep command, cleared by other valid loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep <= 1'b0;
        end else if (load_eff) begin
            if (kind == CMD_SLEEP)         sleep <= 1'b1;
            else if (kind != CMD_RESERVED) sleep <= 1'b0;
        end
    end
endmodule

// File: rtl/quad_dac_ctrl_chk.sv
// Assertion checker for quad_dac_ctrl, attached by bind.
// Assumes it sees the top's strobes and held word.
module quad_dac_ctrl_chk #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 10,
    parameter int ADDR_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     load_stb,
    input logic                     clr_act,
    input logic                     sck_fall,
    input logic                     cs_s,
    input logic [ADDR_W-1:0]        addr,
    input logic [NUM_CH*CODE_W-1:0] code,
    input logic                     sleep,
    input logic                     dout
);
    localparam logic [ADDR_W-1:0] ALL_CODE   = '1;
    localparam logic [ADDR_W-1:0] SLEEP_CODE = ALL_CODE - 1'b1;

    logic is_resv;
    assign is_resv = (addr > ADDR_W'(NUM_CH)) && (addr < SLEEP_CODE);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (code == '0) && !sleep && !dout);

    a_r5_nop_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !clr_act && addr == '0) |=> !sleep && $stable(code));

    a_r6_sleep_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !clr_act && addr == SLEEP_CODE) |=> sleep && $stable(code));

    a_r8_reserved_neutral: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !clr_act && is_resv) |=> $stable(sleep) && $stable(code));

    a_r7_codes_need_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_stb && !clr_act) |=> $stable(code));

    a_r7_sleep_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> $stable(sleep));

    a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (code == '0) && !dout);

    a_r9_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_act && !(sck_fall && !cs_s)) |=> $stable(dout));
endmodule

bind quad_dac_ctrl quad_dac_ctrl_chk #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_stb (load_stb),
    .clr_act  (clr_act),
    .sck_fall (sck_fall),
    .cs_s     (cs_s),
    .addr     (addr),
    .code     (code),
    .sleep    (sleep),
    .dout     (dout)
);

// File: tb/quad_dac_ctrl_bench.sv
module quad_dac_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, din = 1'b0, cs_ld = 1'b1, clr_n = 1'b1;
    logic        dout, sleep;
    logic [39:0] code;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    quad_dac_ctrl u_quad_dac_ctrl (
        .clk(clk), .rst_n(rst_n), .sck(sck), .din(din), .cs_ld(cs_ld),
        .clr_n(clr_n), .dout(dout), .sleep(sleep), .code(code)
    );

    // {word, sleep, ch0, ch1, ch2, ch3}
    localparam logic [56:0] VEC [12] = '{
        {16'h1554, 1'b0, 10'h155, 10'h000, 10'h000, 10'h000},
        {16'h2AA8, 1'b0, 10'h155, 10'h2AA, 10'h000, 10'h000},
        {16'h3FFC, 1'b0, 10'h155, 10'h2AA, 10'h3FF, 10'h000},
        {16'h4004, 1'b0, 10'h155, 10'h2AA, 10'h3FF, 10'h001},
        {16'hE3C0, 1'b1, 10'h155, 10'h2AA, 10'h3FF, 10'h001},
        {16'h548C, 1'b1, 10'h155, 10'h2AA, 10'h3FF, 10'h001},
        {16'h230C, 1'b0, 10'h155, 10'h0C3, 10'h3FF, 10'h001},
        {16'hDEAC, 1'b0, 10'h155, 10'h0C3, 10'h3FF, 10'h001},
        {16'hE003, 1'b1, 10'h155, 10'h0C3, 10'h3FF, 10'h001},
        {16'h0800, 1'b0, 10'h155, 10'h0C3, 10'h3FF, 10'h001},
        {16'hF238, 1'b0, 10'h08E, 10'h08E, 10'h08E, 10'h08E},
        {16'h1FFD, 1'b0, 10'h3FF, 10'h08E, 10'h08E, 10'h08E}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        din = b; waitc(8);
        sck = 1'b1; waitc(8);
        sck = 1'b0; waitc(8);
    endtask

    task automatic frame(input logic [31:0] bits, input int n);
        cs_ld = 1'b0; waitc(8);
        for (int i = 0; i < n; i++) pulse(bits[n-1-i]);
        cs_ld = 1'b1; waitc(12);
    endtask

    function automatic logic [40:0] state_of(input logic s, input logic [39:0] c);
        return {s, c[9:0], c[19:10], c[29:20], c[39:30]};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic prev_sleep;
        string tag;
        waitc(6);
        rst_n = 1'b1;
        waitc(4);
        // R1: reset state
        check("R1 reset", {sleep, dout, code}, 64'h0);

        // Table walk: R3 R4 R5 R6 R7 R8
        prev_sleep = 1'b0;
        for (int k = 0; k < 12; k++) begin
            logic [3:0] a;
            a = VEC[k][56:53];
            frame({16'h0, VEC[k][56:41]}, 16);
            if (a == 4'hE)                      tag = "R6 sleep";
            else if (a == 4'hF)                 tag = "R4 broadcast";
            else if (a == 4'h0)                 tag = "R5 nop";
            else if (a >= 4'h5)                 tag = "R8 reserved";
            else                                tag = "R3 single";
            if (prev_sleep && a != 4'hE && !(a >= 4'h5 && a <= 4'hD))
                tag = {"R7 wake ", tag};
            check(tag, 64'(state_of(sleep, code)), 64'(VEC[k][40:0]));
            prev_sleep = VEC[k][40];
        end

        // R2: sck ignored while cs_ld high
        frame(32'h1444, 16);
        din = 1'b1;
        for (int i = 0; i < 16; i++) begin
            sck = 1'b1; waitc(8); sck = 1'b0; waitc(8);
        end
        frame(32'h0, 0);
        check("R2 cs high ignores sck", 64'(code[9:0]), 64'h111);

        // R10: clear zeroes codes and word, keeps sleep
        frame(32'hE000, 16);
        check("R6 sleep before clear", 64'(sleep), 64'h1);
        clr_n = 1'b0; waitc(10);
        clr_n = 1'b1; waitc(6);
        check("R10 clear codes", {23'h0, sleep, code}, {23'h0, 1'b1, 40'h0});
        frame(32'h0, 0);
        check("R10 cleared word acts as nop", 64'(sleep), 64'h0);

        // R9: dout delay of 16 edges, updated after falling edge
        begin
            logic [31:0] strm;
            strm = {16'h5A3C, 16'h4B54};
            cs_ld = 1'b0; waitc(8);
            for (int n = 1; n <= 32; n++) begin
                pulse(strm[32-n]);
                if (n == 15) check("R9 dout before delay", 64'(dout), 64'h0);
                if (n >= 16) check("R9 dout delayed bit", 64'(dout), 64'(strm[47-n]));
            end
            cs_ld = 1'b1; waitc(12);
            check("R9 last word loaded", 64'(code[39:30]), 64'h2D5);
        end

        // R11: long and short words act on the last 16 bits
        frame({12'h0, 4'hF, 16'h1030}, 20);
        check("R11 long word", 64'(code), 64'({10'h2D5, 10'h000, 10'h000, 10'h00C}));
        frame(32'hB7, 8);
        check("R11 short word", 64'(code[29:20]), 64'h02D);
        check("R11 short word others", 64'(code[9:0]), 64'h00C);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule